// File: doc/BRIEF.md
# Dual-Protocol Configuration Register Port

This block is a slave control port that lets an external controller program a small bank of 8-bit configuration registers. It works over either a two-wire bus with addressing and acknowledge (I2C) or a four-wire serial bus with a chip select (SPI). The protocol is not fixed by a pin strap. After reset the port listens on the shared chip-select/address pin: one high-to-low transition on that pin switches it to SPI, and the choice then holds until the next reset. If no such transition occurs, the port stays in I2C and uses the pin level as the lowest bit of its 7-bit chip address.

Every transfer follows the same order: a chip address byte, then a pointer byte, then data. Bit 7 of the pointer byte turns on auto-increment and bits 6:0 select the register. I2C transfers can both read and write; a repeated START keeps the pointer that was set earlier. SPI transfers can only write. Registers flagged as reserved keep their default value and ignore writes. The `cfg_en_o` output goes high only once two enable bits, which sit in different registers, are both set.

All bus inputs pass through two-flop synchronizers into the system clock domain. START and STOP are recognized from SDA edges that occur while SCL is high.

Top module: `cfg_port`

## Requirements
- R1: While `rst_ni` is low and just after it is released, every register holds its default value. The defaults, register 0 to 7, are 01, 00, 00, 00, A5, 10, 00, 3C hex. At the same time `spi_mode_o`, `cfg_en_o` and `sda_oe_o` are 0.
- R2: A falling edge on `cs_ad0_i` after reset sets `spi_mode_o` to 1, and it stays 1 until the next reset. Without such an edge `spi_mode_o` stays 0, even when the pin is held low.
- R3: In I2C mode the port responds to the 7-bit address {100111, `cs_ad0_i`}. The address byte carries that address in bits 7:1 and the read flag (1 = read) in bit 0. The port acknowledges a matching address by pulling SDA low (`sda_oe_o` = 1) during the ninth clock, and it changes `sda_oe_o` only while SCL is low. A non-matching address gets no acknowledge, and the rest of that transfer is ignored.
- R4: In the pointer byte, bit 7 is the auto-increment flag and bits 6:0 are the register address. A write to an address at or above 8 changes nothing, and a read from such an address returns 00.
- R5: With auto-increment set, the pointer advances by one after each written or read data byte. From register 7 it wraps to register 0.
- R6: With auto-increment clear, the pointer stays on the same register for every data byte.
- R7: An I2C read returns the register at the current pointer, MSB first. A repeated START followed by a read address keeps the pointer that the earlier pointer byte set.
- R8: In SPI mode a transfer is framed by a low `cs_ad0_i` and data is sampled MSB first on rising `cclk_i`. The transfer is accepted only if its first byte is 9C hex (address {100111, 0} with the read flag clear). Any other first byte makes the port ignore the whole transfer. Registers change only while chip select is low.
- R9: Registers 4 and 7 are reserved. They keep their defaults under any write in either mode.
- R10: `cfg_en_o` is 1 exactly when register 3 bit 7 and register 5 bit 0 are both 1. The two bits can be set in either order and in separate transfers, and `cfg_en_o` rises only right after a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain drive) |
| cclk_i | input | 1 | SPI serial clock |
| cdin_i | input | 1 | SPI serial data in |
| cs_ad0_i | input | 1 | SPI chip select (active low) or I2C address bit 0 |
| spi_mode_o | output | 1 | 1 once SPI mode has been detected |
| cfg_en_o | output | 1 | Both enable bits set |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
The bench builds the port with its default parameters: eight registers, registers 4 and 7 reserved, and the enable bits in registers 3 and 5. With only eight registers, a three-byte burst that starts at register 6 crosses the wrap from 7 to 0 and passes over a reserved register in the same transfer. Pointer values of 8 and above also reach the out-of-range path. The bench resets the port three times: with the shared pin held high, with it held low, and with it falling after reset. This covers both I2C address variants and the switch to SPI, and SPI is used to set the enable bits in the order opposite to the I2C run.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int PTR_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK_ADDR,
    ST_ACK_PTR,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } i2c_st_e;
endpackage

// File: rtl/cfg_port_sync.sv
module cfg_port_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfg_port_i2c.sv
module cfg_port_i2c
  import cfg_port_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ad0_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              ptr_v_o,
  output logic              wr_v_o,
  output logic              rd_adv_o,
  output logic [BYTE_W-1:0] byte_o
);
  i2c_st_e           st_q;
  logic              scl_q, sda_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              full_q, rw_q, nack_q, oe_q;
  logic              start, stop, rise, fall;

  assign start = scl_i & scl_q & sda_q & ~sda_i;
  assign stop  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise  = scl_i & ~scl_q;
  assign fall  = ~scl_i & scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start) begin
      st_q   <= ST_ADDR;
      cnt_q  <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (stop) begin
      st_q   <= ST_IDLE;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (rise && !full_q) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end else if (fall && full_q) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == {ADDR_HI, ad0_i}) begin
                rw_q <= sh_q[0];
                oe_q <= 1'b1;
                st_q <= ST_ACK_ADDR;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              oe_q <= 1'b1;
              st_q <= (st_q == ST_PTR) ? ST_ACK_PTR : ST_ACK_WDATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              st_q <= ST_RDATA;
              sh_q <= rd_data_i;
              oe_q <= ~rd_data_i[7];
            end else begin
              st_q <= ST_PTR;
              oe_q <= 1'b0;
            end
          end
        end
        ST_ACK_PTR, ST_ACK_WDATA: begin
          if (fall) begin
            oe_q <= 1'b0;
            st_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (fall) begin
            if (cnt_q == 3'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_RACK;
            end else begin
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (rise) begin
            nack_q <= sda_i;
          end else if (fall) begin
            if (!nack_q) begin
              st_q  <= ST_RDATA;
              sh_q  <= rd_data_i;
              oe_q  <= ~rd_data_i[7];
              cnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
  assign byte_o   = sh_q;
  assign ptr_v_o  = (st_q == ST_PTR) & fall & full_q & ~start & ~stop;
  assign wr_v_o   = (st_q == ST_WDATA) & fall & full_q & ~start & ~stop;
  assign rd_adv_o = (st_q == ST_RDATA) & fall & (cnt_q == 3'd7) & ~start & ~stop;
endmodule

// File: rtl/cfg_port_spi.sv
module cfg_port_spi
  import cfg_port_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cclk_i,
  input  logic              cdin_i,
  input  logic              cs_i,
  output logic              ptr_v_o,
  output logic              wr_v_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic              cclk_q;
  logic [BYTE_W-1:0] sh_q;
  logic [2:0]        cnt_q;
  logic [1:0]        idx_q;
  logic              match_q;
  logic              rise, done;
  logic [BYTE_W-1:0] nxt;

  assign rise = cclk_i & ~cclk_q;
  assign nxt  = {sh_q[BYTE_W-2:0], cdin_i};
  assign done = ~cs_i & rise & (cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_q  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      match_q <= 1'b0;
    end else begin
      cclk_q <= cclk_i;
      if (cs_i) begin
        cnt_q   <= '0;
        idx_q   <= '0;
        match_q <= 1'b0;
      end else if (rise) begin
        sh_q  <= nxt;
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          if (idx_q == 2'd0) match_q <= (nxt == {ADDR_HI, 2'b00});
          if (idx_q != 2'd2) idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  assign ptr_v_o = done & (idx_q == 2'd1) & match_q;
  assign wr_v_o  = done & (idx_q == 2'd2) & match_q;
  assign byte_o  = nxt;
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int                       NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0]      RSVD_MASK = 8'h90,
  parameter logic [NUM_REGS*8-1:0]    RST_VALS  = 64'h3C00_10A5_0000_0001
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PTR_W-1:0]      ptr_i,
  input  logic                  wr_v_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output logic [BYTE_W-1:0]     rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (RSVD_MASK[i]) begin : g_rsvd
      assign regs_o[i*8 +: 8] = RST_VALS[i*8 +: 8];
    end else begin : g_rw
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= RST_VALS[i*8 +: 8];
        else if (wr_v_i && ptr_i == PTR_W'(i))    q <= wdata_i;
      end
      assign regs_o[i*8 +: 8] = q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_i == PTR_W'(i)) rd_data_o = regs_o[i*8 +: 8];
  end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter int                    NUM_REGS  = 8,
  parameter logic [5:0]            ADDR_HI   = 6'b100111,
  parameter logic [NUM_REGS-1:0]   RSVD_MASK = 8'h90,
  parameter logic [NUM_REGS*8-1:0] RST_VALS  = 64'h3C00_10A5_0000_0001,
  parameter int                    EN1_REG   = 3,
  parameter int                    EN1_BIT   = 7,
  parameter int                    EN2_REG   = 5,
  parameter int                    EN2_BIT   = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  cclk_i,
  input  logic                  cdin_i,
  input  logic                  cs_ad0_i,
  output logic                  spi_mode_o,
  output logic                  cfg_en_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic scl_s, sda_s, cclk_s, cdin_s, cs_s, cs_q, spi_q;
  logic i_ptr_v, i_wr_v, i_rd_adv, i_oe, s_ptr_v, s_wr_v;
  logic ptr_v, wr_v, rd_adv, ainc_q;
  logic [BYTE_W-1:0] i_byte, s_byte, in_byte, rd_data;
  logic [PTR_W-1:0]  ptr_q;

  cfg_port_sync #(.W(5)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i, cclk_i, cdin_i, cs_ad0_i}),
    .q_o   ({scl_s, sda_s, cclk_s, cdin_s, cs_s})
  );

  // sticky SPI selection on first falling chip-select edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      spi_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      if (cs_q && !cs_s) spi_q <= 1'b1;
    end
  end

  cfg_port_i2c #(.ADDR_HI(ADDR_HI)) u_i2c (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_s),
    .sda_i    (sda_s),
    .ad0_i    (cs_s),
    .rd_data_i(rd_data),
    .sda_oe_o (i_oe),
    .ptr_v_o  (i_ptr_v),
    .wr_v_o   (i_wr_v),
    .rd_adv_o (i_rd_adv),
    .byte_o   (i_byte)
  );

  cfg_port_spi #(.ADDR_HI(ADDR_HI)) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cclk_i (cclk_s),
    .cdin_i (cdin_s),
    .cs_i   (cs_s),
    .ptr_v_o(s_ptr_v),
    .wr_v_o (s_wr_v),
    .byte_o (s_byte)
  );

  assign ptr_v   = spi_q ? s_ptr_v : i_ptr_v;
  assign wr_v    = spi_q ? s_wr_v  : i_wr_v;
  assign rd_adv  = ~spi_q & i_rd_adv;
  assign in_byte = spi_q ? s_byte  : i_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      ainc_q <= 1'b0;
    end else if (ptr_v) begin
      ptr_q  <= in_byte[PTR_W-1:0];
      ainc_q <= in_byte[7];
    end else if ((wr_v || rd_adv) && ainc_q) begin
      ptr_q  <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  cfg_port_regs #(
    .NUM_REGS (NUM_REGS),
    .RSVD_MASK(RSVD_MASK),
    .RST_VALS (RST_VALS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ptr_i    (ptr_q),
    .wr_v_i   (wr_v),
    .wdata_i  (in_byte),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );

  assign sda_oe_o   = i_oe & ~spi_q;
  assign spi_mode_o = spi_q;
  assign cfg_en_o   = regs_o[EN1_REG*8 + EN1_BIT] & regs_o[EN2_REG*8 + EN2_BIT];
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  spi_mode_i,
  input logic                  cfg_en_i,
  input logic                  sda_oe_i,
  input logic                  scl_s_i,
  input logic                  cs_s_i,
  input logic                  wr_v_i,
  input logic                  ainc_i,
  input logic [6:0]            ptr_i,
  input logic [NUM_REGS*8-1:0] regs_i
);
  localparam logic [6:0] LAST = 7'(NUM_REGS - 1);

  // R2
  spi_mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_i |=> spi_mode_i);

  // R10
  cfg_en_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_en_i) |-> $past(wr_v_i));

  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_i && !ainc_i) |=> $stable(ptr_i));

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_i && ainc_i && ptr_i != LAST) |=> (ptr_i == $past(ptr_i) + 7'd1));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_v_i && ainc_i && ptr_i == LAST) |=> (ptr_i == 7'd0));

  // R3
  sda_change_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !$past(scl_s_i));

  // R8
  spi_cs_high_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_mode_i && cs_s_i && $past(cs_s_i)) |-> $stable(regs_i));
endmodule

bind cfg_port cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .spi_mode_i(spi_mode_o),
  .cfg_en_i  (cfg_en_o),
  .sda_oe_i  (sda_oe_o),
  .scl_s_i   (scl_s),
  .cs_s_i    (cs_s),
  .wr_v_i    (wr_v),
  .ainc_i    (ainc_q),
  .ptr_i     (ptr_q),
  .regs_i    (regs_o)
);

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam logic [6:0] A_HI = 7'h4F;
  localparam logic [6:0] A_LO = 7'h4E;
  localparam logic [7:0] SPI_CHIP = 8'h9C;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, cclk = 0, cdin = 0, cs = 1;
  logic sda_oe, spi_mode, cfg_en;
  logic [63:0] regs;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit busy = 1;

  logic [7:0] mreg [8];
  int  mptr;
  bit  mainc;
  localparam logic [7:0] RSVD = 8'h90;
  localparam logic [63:0] DEFS = 64'h3C00_10A5_0000_0001;

  cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cclk_i(cclk), .cdin_i(cdin), .cs_ad0_i(cs),
    .spi_mode_o(spi_mode), .cfg_en_o(cfg_en), .regs_o(regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mpack();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mreg[i];
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) mreg[i] = DEFS[i*8 +: 8];
    mptr = 0; mainc = 0;
  endtask
  task automatic m_adv();
    if (mainc) mptr = (mptr == 7) ? 0 : (mptr + 1) % 128;
  endtask
  task automatic m_ptr(input logic [7:0] b);
    mainc = b[7]; mptr = int'(b[6:0]);
  endtask
  task automatic m_wr(input logic [7:0] d);
    if (mptr < 8 && !RSVD[mptr]) mreg[mptr] = d;
    m_adv();
  endtask
  task automatic m_rd(output logic [7:0] d);
    d = (mptr < 8) ? mreg[mptr] : 8'h00;
    m_adv();
  endtask

  // cycle-by-cycle comparison against the model while no transfer is in flight
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      chk(regs == mpack(), "R9 register image", regs, mpack());
      chk(cfg_en == (mreg[3][7] & mreg[5][0]), "R10 cfg_en", cfg_en, mreg[3][7] & mreg[5][0]);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic cs_lvl);
    busy = 1;
    rst_n = 0; cs = cs_lvl; scl_m = 1; sda_m = 1; cclk = 0; cdin = 0;
    m_reset();
    wt(4);
    chk(regs == DEFS, "R1 defaults", regs, DEFS);
    chk(!spi_mode && !cfg_en && !sda_oe, "R1 outputs", {spi_mode, cfg_en, sda_oe}, 0);
    rst_n = 1;
    wt(6);
    chk(!spi_mode && !cfg_en && !sda_oe, "R1 outputs after release", {spi_mode, cfg_en, sda_oe}, 0);
    busy = 0;
  endtask

  task automatic i2c_start();
    sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(H);
  endtask
  task automatic i2c_stop();
    sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H);
  endtask
  task automatic i2c_tx(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1; wt(H); scl_m = 0; wt(2);
    end
    sda_m = 1; wt(H); scl_m = 1; wt(H/2);
    ack = (sda_bus == 1'b0);
    wt(H/2); scl_m = 0; wt(H);
  endtask
  task automatic i2c_rx(input bit ack, output logic [7:0] v);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wt(H); scl_m = 1; wt(H/2); v = {v[6:0], sda_bus}; wt(H/2); scl_m = 0; wt(2);
    end
    sda_m = ack ? 1'b0 : 1'b1; wt(H); scl_m = 1; wt(H); scl_m = 0; wt(2); sda_m = 1; wt(H);
  endtask

  task automatic i2c_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d[$], input bit exp_ack);
    bit ack;
    busy = 1;
    i2c_start();
    i2c_tx({a, 1'b0}, ack);
    chk(ack == exp_ack, "R3 address acknowledge", ack, exp_ack);
    if (ack) begin
      i2c_tx(p, ack);
      chk(ack, "R4 pointer acknowledge", ack, 1);
      m_ptr(p);
      foreach (d[k]) begin
        i2c_tx(d[k], ack);
        chk(ack, "R3 data acknowledge", ack, 1);
        m_wr(d[k]);
      end
    end
    i2c_stop(); wt(4);
    busy = 0;
  endtask

  task automatic i2c_read(input logic [6:0] a, input logic [7:0] p, input int n, input string req);
    bit ack;
    logic [7:0] v, e;
    busy = 1;
    i2c_start();
    i2c_tx({a, 1'b0}, ack);
    i2c_tx(p, ack);
    m_ptr(p);
    i2c_start();
    i2c_tx({a, 1'b1}, ack);
    chk(ack, "R7 read address acknowledge", ack, 1);
    for (int k = 0; k < n; k++) begin
      i2c_rx(k != n - 1, v);
      m_rd(e);
      chk(v == e, req, v, e);
    end
    i2c_stop(); wt(4);
    busy = 0;
  endtask

  task automatic spi_write(input logic [7:0] chip, input logic [7:0] p, input logic [7:0] d[$]);
    logic [7:0] bytes[$];
    busy = 1;
    bytes = {chip, p};
    foreach (d[k]) bytes.push_back(d[k]);
    cs = 0; wt(H);
    foreach (bytes[k])
      for (int i = 7; i >= 0; i--) begin
        cdin = bytes[k][i]; wt(H); cclk = 1; wt(H); cclk = 0;
      end
    wt(H); cs = 1; wt(H);
    if (chip == SPI_CHIP) begin
      m_ptr(p);
      foreach (d[k]) m_wr(d[k]);
    end
    wt(4);
    busy = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // ---- I2C with address bit 0 high ----
    do_reset(1'b1);
    i2c_write(A_HI, 8'h81, '{8'h11, 8'h22, 8'h33}, 1);              // R5 burst
    chk(regs[31:8] == 24'h332211, "R5 burst write", regs[31:8], 24'h332211);
    i2c_write(A_HI, 8'h02, '{8'h44, 8'h55}, 1);                     // R6
    chk(regs[23:16] == 8'h55, "R6 no-increment write", regs[23:16], 8'h55);
    i2c_read(A_HI, 8'h81, 3, "R7 read after repeated start");
    i2c_write(A_HI, 8'h86, '{8'h66, 8'h77, 8'h88}, 1);              // R5 wrap, R9
    chk(regs[7:0] == 8'h88 && regs[63:56] == 8'h3C, "R5 wrap to 0", regs, mpack());
    i2c_read(A_HI, 8'h86, 3, "R5 read across wrap");
    i2c_write(A_HI, 8'h04, '{8'h00}, 1);
    chk(regs[39:32] == 8'hA5, "R9 reserved write ignored", regs[39:32], 8'hA5);
    i2c_read(A_HI, 8'h04, 1, "R9 reserved read");
    i2c_write(A_LO, 8'h01, '{8'hEE}, 0);                            // R3 mismatch
    chk(regs[15:8] == 8'h11, "R3 foreign address ignored", regs[15:8], 8'h11);
    i2c_write(A_HI, 8'h03, '{8'h80}, 1);                            // R10 first bit
    chk(!cfg_en, "R10 one enable bit only", cfg_en, 0);
    i2c_write(A_HI, 8'h05, '{8'h11}, 1);
    chk(cfg_en, "R10 both enable bits", cfg_en, 1);
    i2c_write(A_HI, 8'h20, '{8'h99}, 1);                            // R4 out of range
    chk(regs == mpack(), "R4 out-of-range write", regs, mpack());
    i2c_read(A_HI, 8'h20, 1, "R4 out-of-range read");
    i2c_read(A_HI, 8'h05, 2, "R6 read without increment");
    chk(!spi_mode, "R2 stays I2C with pin high", spi_mode, 0);

    // ---- I2C with address bit 0 low ----
    do_reset(1'b0);
    i2c_write(A_HI, 8'h01, '{8'h5A}, 0);
    chk(regs[15:8] == 8'h00, "R3 bit0=1 ignored when pin low", regs[15:8], 8'h00);
    i2c_write(A_LO, 8'h01, '{8'h5A}, 1);
    chk(regs[15:8] == 8'h5A, "R3 address bit 0 from pin", regs[15:8], 8'h5A);
    chk(!spi_mode, "R2 stays I2C with pin low", spi_mode, 0);

    // ---- SPI ----
    do_reset(1'b1);
    chk(!spi_mode, "R2 before chip-select edge", spi_mode, 0);
    spi_write(SPI_CHIP, 8'h05, '{8'h01});
    chk(spi_mode, "R2 SPI detected", spi_mode, 1);
    chk(!cfg_en, "R10 reverse order first bit", cfg_en, 0);
    spi_write(SPI_CHIP, 8'h03, '{8'h80});
    chk(cfg_en, "R10 reverse order both bits", cfg_en, 1);
    spi_write(SPI_CHIP, 8'h80, '{8'hA1, 8'hB2});
    chk(regs[15:0] == 16'hB2A1, "R8 SPI burst", regs[15:0], 16'hB2A1);
    spi_write(SPI_CHIP, 8'h02, '{8'hC3, 8'hD4});
    chk(regs[23:16] == 8'hD4, "R6 SPI no increment", regs[23:16], 8'hD4);
    spi_write(8'h9D, 8'h80, '{8'h00, 8'h00});
    chk(regs[15:0] == 16'hB2A1, "R8 read flag rejected", regs[15:0], 16'hB2A1);
    spi_write(SPI_CHIP, 8'h84, '{8'h00});
    chk(regs[39:32] == 8'hA5, "R9 SPI reserved", regs[39:32], 8'hA5);
    chk(spi_mode, "R2 SPI sticky", spi_mode, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule